// File: doc/BRIEF.md
# Dual-Channel Attenuator Gain Controller

This block is the digital control front end of a two-channel stepped attenuator. Each channel carries a 6-bit attenuation code in which each bit adds a fixed loss. Bit 5 is worth 16 dB and each lower bit is worth half the bit above it, down to 0.5 dB at bit 0. Code 000000 gives the highest gain and 111111 the lowest. The controller also drives an enable and a standby indication for each channel.

A mode pin chooses where the codes come from. When the pin is high, each channel's code follows its own 6-bit pin bus. When the pin is low, a three-wire serial port (active-low select, clock, data) delivers 16-bit frames. Each frame is an address byte followed by a data byte. Bit 1 of the address byte picks the channel and bit 0 is that channel's enable. The data byte carries the code. A frame is written into the register of the addressed channel when the select line returns high. All inputs are asynchronous to the block clock and pass through two-flop synchronisers. Serial clock edges are detected by oversampling at the block clock.

Top module: `dual_atten_ctrl`

## Requirements
- R1: When the synchronised mode pin is high, the block is in parallel mode and the code outputs come from the pin buses. When the pin is low, the block is in serial mode and the code outputs come from the channel registers. Out of reset the mode is taken as parallel until the pin has been sampled.
- R2: In parallel mode, a change on a pin bus reaches the matching code output on the second rising clock edge after the change, and not on the first.
- R3: The serial port accepts frames only after the mode pin has been seen low for SETTLE_CYC clocks. A frame whose select went low before that point is dropped whole.
- R4: A frame is 16 data bits sampled on rising serial-clock edges while select is low, most significant bit first. The address byte comes first, then the data byte.
- R5: In the address byte, bit 1 selects the channel (0 = A, 1 = B) and bit 0 is that channel's enable (1 = on). Address bits 7..2 have no effect.
- R6: The code is taken from bits 5..0 of the data byte, with bit 5 as the MSB. Data bits 7..6 have no effect.
- R7: The frame is written on the rising edge of select, into the addressed channel only. The other channel keeps its code and enable.
- R8: A frame with fewer or more than 16 serial-clock rising edges between select falling and select rising changes neither channel.
- R9: After reset, both channel registers hold code 000000 with the enable set.
- R10: A channel's enable output is high only when its active-low standby pin is high and, in addition, either the block is in parallel mode or the channel's enable bit is set. A channel's standby output is the synchronised inverse of its standby pin.
- R11: Frames sent while in parallel mode have no effect. On a return to serial mode, the register values held before the switch appear again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode_i | input | 1 | Mode pin: 1 parallel, 0 serial |
| gpin_a_i | input | 6 | Channel A code pins |
| gpin_b_i | input | 6 | Channel B code pins |
| ser_csn_i | input | 1 | Serial select, active low |
| ser_sck_i | input | 1 | Serial clock |
| ser_sdi_i | input | 1 | Serial data |
| stby_n_a_i | input | 1 | Channel A standby, active low |
| stby_n_b_i | input | 1 | Channel B standby, active low |
| gain_a_o | output | 6 | Channel A attenuation code |
| gain_b_o | output | 6 | Channel B attenuation code |
| en_a_o | output | 1 | Channel A enable |
| en_b_o | output | 1 | Channel B enable |
| sby_a_o | output | 1 | Channel A in standby |
| sby_b_o | output | 1 | Channel B in standby |

## Verification
A sequence of serial frames writes each channel in turn with both enable values. Because the other channel is checked after every write, a write that reaches the wrong register shows up as a change there. Frames with reserved bits set to ones show whether the decode looks at the right bit positions. Frames with 15 and with 17 clocks show whether the bit count is exact. In parallel mode the code output is sampled one and two edges after a pin change, which pins down the synchroniser depth. Frames sent in parallel mode, and frames started while the mode pin is still settling, must leave the registers untouched; this separates the mode gating from the framing logic.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  localparam int CODE_W     = 6;
  localparam int BYTE_W     = 8;
  localparam int FRAME_W    = 2 * BYTE_W;
  localparam int CH_SEL_POS = 1;
  localparam int EN_POS     = 0;
  localparam int NCH        = 2;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } chan_word_t;
endpackage

// File: rtl/dgc_sync.sv
module dgc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dgc_mode_ctl.sv
module dgc_mode_ctl #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic par_s,
  output logic ser_ready
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (par_s)            low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  assign ser_ready = !par_s && (low_cnt == LIMIT);

  // R3
  ready_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_ready) |-> $past(!par_s));
endmodule

// File: rtl/dgc_spi_rx.sv
module dgc_spi_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               csn_s,
  input  logic               sck_s,
  input  logic               sdi_s,
  output logic               commit,
  output logic [FRAME_W-1:0] frame
);
  localparam int CW = $clog2(FRAME_W + 2);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);
  localparam logic [CW-1:0] SAT  = CW'(FRAME_W + 1);

  logic               csn_q, sck_q, armed;
  logic [CW-1:0]      cnt;
  logic [FRAME_W-1:0] shreg;
  logic               csn_fall, csn_rise, sck_rise;

  assign csn_fall = csn_q & ~csn_s;
  assign csn_rise = ~csn_q & csn_s;
  assign sck_rise = ~sck_q & sck_s & ~csn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (!enable) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (csn_fall) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (csn_rise) begin
      armed <= 1'b0;
    end else if (armed && sck_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_s};
      if (cnt != SAT) cnt <= cnt + 1'b1;
    end
  end

  assign commit = enable & armed & csn_rise & (cnt == FULL);
  assign frame  = shreg;

  // R4
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && csn_fall) |=> (cnt == '0) && armed);

  // R3
  idle_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !armed);
endmodule

// File: rtl/dgc_chan_reg.sv
module dgc_chan_reg
  import dgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  chan_word_t din,
  output chan_word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.en   <= 1'b1;
      q.code <= '0;
    end else if (wr) begin
      q <= din;
    end
  end

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(din)));

  // R7
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/dual_atten_ctrl.sv
module dual_atten_ctrl
  import dgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode_i,
  input  logic [CODE_W-1:0] gpin_a_i,
  input  logic [CODE_W-1:0] gpin_b_i,
  input  logic              ser_csn_i,
  input  logic              ser_sck_i,
  input  logic              ser_sdi_i,
  input  logic              stby_n_a_i,
  input  logic              stby_n_b_i,
  output logic [CODE_W-1:0] gain_a_o,
  output logic [CODE_W-1:0] gain_b_o,
  output logic              en_a_o,
  output logic              en_b_o,
  output logic              sby_a_o,
  output logic              sby_b_o
);
  localparam int CTRL_W = 6;
  localparam logic [CTRL_W-1:0] CTRL_RST = 6'b110011;
  localparam int PIN_W  = NCH * CODE_W;

  logic [CTRL_W-1:0] ctrl_s;
  logic [PIN_W-1:0]  pins_s;
  logic par_s, csn_s, sck_s, sdi_s, stby_a_s, stby_b_s;

  dgc_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({par_mode_i, ser_csn_i, ser_sck_i, ser_sdi_i, stby_n_a_i, stby_n_b_i}),
    .q(ctrl_s));

  dgc_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .d({gpin_b_i, gpin_a_i}),
    .q(pins_s));

  assign {par_s, csn_s, sck_s, sdi_s, stby_a_s, stby_b_s} = ctrl_s;

  logic ser_ready;
  dgc_mode_ctl #(.SETTLE_CYC(SETTLE_CYC)) u_mode (
    .clk(clk), .rst_n(rst_n), .par_s(par_s), .ser_ready(ser_ready));

  logic               commit;
  logic [FRAME_W-1:0] frame;
  dgc_spi_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(ser_ready),
    .csn_s(csn_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .commit(commit), .frame(frame));

  logic [BYTE_W-1:0] addr_byte, data_byte;
  chan_word_t        new_word;
  assign addr_byte     = frame[FRAME_W-1 -: BYTE_W];
  assign data_byte     = frame[BYTE_W-1:0];
  assign new_word.en   = addr_byte[EN_POS];
  assign new_word.code = data_byte[CODE_W-1:0];

  chan_word_t            chan_q [NCH];
  logic [NCH-1:0]        chan_wr;
  logic [NCH-1:0][CODE_W-1:0] gain_v;
  logic [NCH-1:0]        en_v, stby_v;

  assign stby_v = {stby_b_s, stby_a_s};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign chan_wr[ch] = commit && (int'(addr_byte[CH_SEL_POS]) == ch);

    dgc_chan_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr(chan_wr[ch]),
      .din(new_word), .q(chan_q[ch]));

    assign gain_v[ch] = par_s ? pins_s[ch*CODE_W +: CODE_W] : chan_q[ch].code;
    assign en_v[ch]   = (par_s | chan_q[ch].en) & stby_v[ch];
  end

  assign gain_a_o = gain_v[0];
  assign gain_b_o = gain_v[1];
  assign en_a_o   = en_v[0];
  assign en_b_o   = en_v[1];
  assign sby_a_o  = ~stby_a_s;
  assign sby_b_o  = ~stby_b_s;

  // R11
  commit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ser_ready);
endmodule

// File: tb/sim_dual_atten_ctrl.sv
module sim_dual_atten_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {addr, data, nbits, expected A {en,code}, expected B {en,code}}
  localparam logic [34:0] VEC [NVEC] = '{
    {8'h01, 8'h15, 5'd16, 7'h55, 7'h40},
    {8'h02, 8'h3F, 5'd16, 7'h55, 7'h3F},
    {8'h00, 8'h2A, 5'd16, 7'h2A, 7'h3F},
    {8'h03, 8'h01, 5'd16, 7'h2A, 7'h41},
    {8'h01, 8'h3F, 5'd15, 7'h2A, 7'h41},
    {8'h03, 8'h00, 5'd17, 7'h2A, 7'h41},
    {8'hFD, 8'hC7, 5'd16, 7'h47, 7'h41},
    {8'hFE, 8'h00, 5'd16, 7'h47, 7'h00}
  };

  logic clk = 0, rst_n = 0, par_mode = 0;
  logic [5:0] gpin_a = 6'h11, gpin_b = 6'h22;
  logic csn = 1, sck = 0, sdi = 0, stby_a = 1, stby_b = 1;
  logic [5:0] gain_a, gain_b;
  logic en_a, en_b, sby_a, sby_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_atten_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .par_mode_i(par_mode),
    .gpin_a_i(gpin_a), .gpin_b_i(gpin_b),
    .ser_csn_i(csn), .ser_sck_i(sck), .ser_sdi_i(sdi),
    .stby_n_a_i(stby_a), .stby_n_b_i(stby_b),
    .gain_a_o(gain_a), .gain_b_o(gain_b),
    .en_a_o(en_a), .en_b_o(en_b), .sby_a_o(sby_a), .sby_b_o(sby_b));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] a, logic [7:0] d, int nbits);
    logic [15:0] f;
    f = {a, d};
    @(negedge clk) csn = 0;
    wait_cyc(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? f[15-i] : 1'b0;
      wait_cyc(4);
      sck = 1;
      wait_cyc(4);
      sck = 0;
    end
    wait_cyc(4);
    csn = 1;
    wait_cyc(12);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1;
    wait_cyc(25);
    // R9 reset register contents visible in serial mode; R10 standby outputs
    check("R9 reset", {2'b0, en_a, gain_a, en_b, gain_b}, {2'b0, 7'h40, 7'h40});
    check("R10 standby idle", {14'b0, sby_a, sby_b}, 16'h0000);

    // R4 R5 R6 R7 R8 frame table
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][34:27], VEC[v][26:19], int'(VEC[v][18:14]));
      check($sformatf("R4/R5/R6/R7/R8 vec%0d", v),
            {2'b0, en_a, gain_a, en_b, gain_b}, {2'b0, VEC[v][13:7], VEC[v][6:0]});
    end

    // R10 standby forces enable low in serial mode
    stby_a = 0;
    wait_cyc(5);
    check("R10 stby serial", {8'b0, sby_a, en_a, gain_a}, {8'b0, 2'b10, 6'h07});
    stby_a = 1;
    wait_cyc(5);

    // R1 parallel mode selects pin buses
    par_mode = 1;
    wait_cyc(5);
    check("R1 parallel codes", {4'b0, gain_a, gain_b}, {4'b0, 6'h11, 6'h22});
    // R10 enable forced on in parallel even though B bit is clear
    check("R10 par enable", {14'b0, en_a, en_b}, 16'h0003);

    // R2 two-edge latency
    @(posedge clk);
    #1 gpin_a = 6'h2C;
    @(negedge clk);
    check("R2 edge0", {10'b0, gain_a}, {10'b0, 6'h11});
    @(negedge clk);
    check("R2 edge1", {10'b0, gain_a}, {10'b0, 6'h11});
    @(negedge clk);
    check("R2 edge2", {10'b0, gain_a}, {10'b0, 6'h2C});

    // R11 frames in parallel mode are ignored, registers reappear
    send_frame(8'h01, 8'h3F, 16);
    par_mode = 0;
    wait_cyc(30);
    check("R11 held regs", {2'b0, en_a, gain_a, en_b, gain_b}, {2'b0, 7'h47, 7'h00});

    // R3 frame started before settle is dropped
    par_mode = 1;
    wait_cyc(5);
    par_mode = 0;
    send_frame(8'h01, 8'h3A, 16);
    check("R3 early frame", {2'b0, en_a, gain_a, en_b, gain_b}, {2'b0, 7'h47, 7'h00});
    send_frame(8'h01, 8'h3A, 16);
    check("R3 settled frame", {2'b0, en_a, gain_a, en_b, gain_b}, {2'b0, 7'h7A, 7'h00});

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule